// File: doc/BRIEF.md
# SMI/SCI Event Routing Controller

This block gathers power-management and general-purpose pin events and steers each one to one of two interrupt lines. One is a system management interrupt (SMI) and the other is a system control interrupt (SCI). Every event source owns a sticky status bit. Most sources also have an enable bit. Software reaches all of this state through a small register port with eight word addresses. Status bits are cleared by writing a one to them, and enable and control fields are plain read/write.

There are sixteen GPIO pins, eight in the core well and eight in the suspend well. Each pin carries a two-bit route code that picks the SCI path, the SMI path or neither. A pin's status is recorded only when its route and the matching enable agree.

The other event sources are:
- four active-low PCIe wake inputs;
- a USB write-enable edge;
- a power-button override, which also pulses a request to enter S5;
- a global-status request, which drives SCI whatever the SCI enable says;
- a synchronous SMI request, whose completion is held back until a separate acknowledge arrives.

Top module: `evr_router`

## Requirements
- R1: A GPIO SCI status bit is set on a rising edge of its pin only when the pin's route code is 10b and its SCI enable bit is 1.
- R2: A GPIO SMI status bit is set on a rising edge of its pin only when the route code is 01b and its SMI enable bit is 1. Route codes 00b and 11b set neither status bit.
- R3: The register fields sit at fixed positions:
  - Address 3 holds GPIO SCI status and address 4 holds GPIO SCI enable. In both, core pins 7..0 are at bits 31..24 and suspend pins 7..0 are at bits 23..16.
  - Address 5 holds the GPIO SMI fields. Core status is at bits 31..24, suspend status at 23..16, core enables at 15..8 and suspend enables at 7..0.
  - Address 7 holds the route codes. Suspend pin k uses bits [2k+1:2k] and core pin k uses bits [2k+17:2k+16].
- R4: While PCIe wake input n is held low, wake status bit n (address 1, bit 2+n) is set whatever its enable says. That status drives SCI only when its enable (address 2, bit n) and the SCI enable are both 1.
- R5: A 0-to-1 change on the USB write-enable input sets both USB status bits (address 6, bits 0 and 1). SMI results only when both USB enable bits (address 6, bits 2 and 3) and the global SMI enable are all 1.
- R6: A rising edge on the power-button override input does two things. It pulses s5_req_o high for exactly one cycle, and it sets the override status bit (address 1, bit 0). That bit survives later activity until software clears it. It drives SCI only while the SCI enable is 1, so clearing it before setting the enable avoids the SCI.
- R7: A global-status request sets the global status bit (address 1, bit 1). That bit drives SCI even while the SCI enable (address 0, bit 0) is 0.
- R8: SMI is the OR of all enabled SMI status terms, gated by the global SMI enable (address 0, bit 1). SCI is the OR of all enabled SCI status terms, gated by the SCI enable. Both outputs are levels.
- R9: Writing a 1 to a status bit clears it. An event arriving in the same cycle as that clear wins, and the bit stays set.
- R10: A synchronous SMI request sets status bit 6 at address 1, which raises SMI under the global SMI enable. It also marks a completion as pending. ssmi_cmpl_o pulses for one cycle, in the cycle after ssmi_ack_i is seen while the completion is pending, and never at any other time.
- R11: After reset every register reads zero and all outputs are low.
- R12: GPIO and wake inputs pass through a two-flop synchronizer. GPIO status reacts only to rising edges, so a pin held high does not set its status again after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_core_i | input | 8 | Core-well GPIO pins (asynchronous) |
| gpio_sus_i | input | 8 | Suspend-well GPIO pins (asynchronous) |
| pcie_wake_n_i | input | 4 | Active-low PCIe wake inputs (asynchronous) |
| usb_we_i | input | 1 | USB write-enable level; its rising edge is the event |
| pwrbtn_ovr_i | input | 1 | Power-button override; its rising edge is the event |
| gbl_req_i | input | 1 | Global-status request pulse |
| ssmi_req_i | input | 1 | Synchronous SMI request pulse |
| ssmi_ack_i | input | 1 | Synchronous SMI acknowledge |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| smi_o | output | 1 | SMI level |
| sci_o | output | 1 | SCI level |
| ssmi_cmpl_o | output | 1 | Synchronous SMI completion pulse |
| s5_req_o | output | 1 | One-cycle request to enter S5 |

## Verification
The bench steps every route code through all four enable combinations, on one suspend pin and one core pin. A design that decoded the route bits swapped, or that recorded status regardless of enable, would show a status bit in the wrong register. The bench clears status bits while the event is still active, and checks that a design giving the clear priority would lose a held wake or a coincident global request. It also checks that the global status raises SCI with the SCI enable off. It holds the acknowledge back to show that a design answering early would pulse its completion too soon. Finally, it sets the SCI enable after a button override and confirms the leftover status raises SCI.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_PM_STS  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PM_EN   = 3'd2;
  localparam logic [ADDR_W-1:0] A_GPE_STS = 3'd3;
  localparam logic [ADDR_W-1:0] A_GPE_EN  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ALT_SMI = 3'd5;
  localparam logic [ADDR_W-1:0] A_USB     = 3'd6;
  localparam logic [ADDR_W-1:0] A_ROUTE   = 3'd7;

  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_SMI  = 2'b01,
    RT_SCI  = 2'b10,
    RT_RSVD = 2'b11
  } route_e;

  // a pin's status is recorded only when its route and enable agree
  function automatic logic route_hit(input logic [1:0] rt, input route_e want, input logic en);
    return (route_e'(rt) == want) && en;
  endfunction

  // sticky status update: the event wins over a same-cycle clear
  function automatic logic [15:0] w1c16(input logic [15:0] cur, input logic [15:0] set,
                                        input logic [15:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/evr_sync.sv
module evr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/evr_gpio_lane.sv
module evr_gpio_lane
  import evr_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_sync,
  input  logic [2*NPIN-1:0] route,
  input  logic [NPIN-1:0]   sci_en,
  input  logic [NPIN-1:0]   smi_en,
  output logic [NPIN-1:0]   pin_rise,
  output logic [NPIN-1:0]   sci_set,
  output logic [NPIN-1:0]   smi_set
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_sync;
  end

  assign pin_rise = pin_sync & ~prev_q;

  for (genvar j = 0; j < NPIN; j++) begin : g_pin
    assign sci_set[j] = pin_rise[j] && route_hit(route[2*j +: 2], RT_SCI, sci_en[j]);
    assign smi_set[j] = pin_rise[j] && route_hit(route[2*j +: 2], RT_SMI, smi_en[j]);
  end
endmodule

// File: rtl/evr_ssmi.sv
module evr_ssmi (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack,
  output logic pend,
  output logic cmpl
);
  logic pend_q, cmpl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cmpl_q <= 1'b0;
    end else begin
      cmpl_q <= pend_q && ack;
      pend_q <= (pend_q && !ack) || req;
    end
  end

  assign pend = pend_q;
  assign cmpl = cmpl_q;
endmodule

// File: rtl/evr_router.sv
module evr_router
  import evr_pkg::*;
#(
  parameter int HALF_PINS   = 8,
  parameter int NWAKE       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HALF_PINS-1:0] gpio_core_i,
  input  logic [HALF_PINS-1:0] gpio_sus_i,
  input  logic [NWAKE-1:0]     pcie_wake_n_i,
  input  logic                 usb_we_i,
  input  logic                 pwrbtn_ovr_i,
  input  logic                 gbl_req_i,
  input  logic                 ssmi_req_i,
  input  logic                 ssmi_ack_i,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 smi_o,
  output logic                 sci_o,
  output logic                 ssmi_cmpl_o,
  output logic                 s5_req_o
);
  localparam int NPIN   = 2 * HALF_PINS;
  localparam int PM_W   = 3 + NWAKE;
  localparam int B_PBOR = 0;
  localparam int B_GBL  = 1;
  localparam int B_WAKE = 2;
  localparam int B_SSMI = 2 + NWAKE;

  // ---------------- input conditioning ----------------
  logic [NPIN-1:0]  pin_sync;
  logic [NWAKE-1:0] wake_act;

  evr_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d({gpio_core_i, gpio_sus_i}), .q(pin_sync));

  evr_sync #(.W(NWAKE), .STAGES(SYNC_STAGES)) u_wake_sync (
    .clk(clk), .rst_n(rst_n), .d(~pcie_wake_n_i), .q(wake_act));

  logic usb_prev_q, pbor_prev_q;
  logic usb_rise, pbor_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usb_prev_q  <= 1'b0;
      pbor_prev_q <= 1'b0;
    end else begin
      usb_prev_q  <= usb_we_i;
      pbor_prev_q <= pwrbtn_ovr_i;
    end
  end

  assign usb_rise  = usb_we_i && !usb_prev_q;
  assign pbor_rise = pwrbtn_ovr_i && !pbor_prev_q;

  // ---------------- registers ----------------
  logic [1:0]        ctrl_q;        // [0] SCI enable, [1] global SMI enable
  logic [PM_W-1:0]   pm_sts_q;
  logic [NWAKE-1:0]  wake_en_q;
  logic [NPIN-1:0]   gpe_sts_q, gpe_en_q;
  logic [NPIN-1:0]   alt_sts_q, alt_en_q;
  logic [1:0]        usb_sts_q, usb_en_q;
  logic [2*NPIN-1:0] route_q;
  logic              s5_q;

  logic sci_en, smi_gen;
  assign sci_en  = ctrl_q[0];
  assign smi_gen = ctrl_q[1];

  // ---------------- GPIO lanes ----------------
  logic [NPIN-1:0] pin_rise, gpio_sci_set, gpio_smi_set;

  evr_gpio_lane #(.NPIN(NPIN)) u_lane (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .route(route_q),
    .sci_en(gpe_en_q), .smi_en(alt_en_q),
    .pin_rise(pin_rise), .sci_set(gpio_sci_set), .smi_set(gpio_smi_set));

  // ---------------- sync SMI handshake ----------------
  logic ssmi_pend;

  evr_ssmi u_ssmi (
    .clk(clk), .rst_n(rst_n), .req(ssmi_req_i), .ack(ssmi_ack_i),
    .pend(ssmi_pend), .cmpl(ssmi_cmpl_o));

  // ---------------- write decode (named for the checker) ----------------
  logic wr_ctrl, wr_pm_sts, wr_pm_en, wr_gpe_sts, wr_gpe_en, wr_alt, wr_usb, wr_route;
  assign wr_ctrl    = reg_wr_i && (reg_addr_i == A_CTRL);
  assign wr_pm_sts  = reg_wr_i && (reg_addr_i == A_PM_STS);
  assign wr_pm_en   = reg_wr_i && (reg_addr_i == A_PM_EN);
  assign wr_gpe_sts = reg_wr_i && (reg_addr_i == A_GPE_STS);
  assign wr_gpe_en  = reg_wr_i && (reg_addr_i == A_GPE_EN);
  assign wr_alt     = reg_wr_i && (reg_addr_i == A_ALT_SMI);
  assign wr_usb     = reg_wr_i && (reg_addr_i == A_USB);
  assign wr_route   = reg_wr_i && (reg_addr_i == A_ROUTE);

  logic [PM_W-1:0] pm_set, pm_clr;
  logic            pbor_clr;
  assign pm_set   = {ssmi_req_i, wake_act, gbl_req_i, pbor_rise};
  assign pm_clr   = wr_pm_sts ? reg_wdata_i[PM_W-1:0] : '0;
  assign pbor_clr = pm_clr[B_PBOR];

  logic [NPIN-1:0] gpe_clr, alt_clr;
  assign gpe_clr = wr_gpe_sts ? reg_wdata_i[16 +: NPIN] : '0;
  assign alt_clr = wr_alt     ? reg_wdata_i[16 +: NPIN] : '0;

  logic [1:0] usb_clr;
  assign usb_clr = wr_usb ? reg_wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      pm_sts_q  <= '0;
      wake_en_q <= '0;
      gpe_sts_q <= '0;
      gpe_en_q  <= '0;
      alt_sts_q <= '0;
      alt_en_q  <= '0;
      usb_sts_q <= '0;
      usb_en_q  <= '0;
      route_q   <= '0;
      s5_q      <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q    <= reg_wdata_i[1:0];
      if (wr_pm_en)  wake_en_q <= reg_wdata_i[NWAKE-1:0];
      if (wr_gpe_en) gpe_en_q  <= reg_wdata_i[16 +: NPIN];
      if (wr_alt)    alt_en_q  <= reg_wdata_i[NPIN-1:0];
      if (wr_usb)    usb_en_q  <= reg_wdata_i[3:2];
      if (wr_route)  route_q   <= reg_wdata_i[2*NPIN-1:0];
      pm_sts_q  <= (pm_sts_q & ~pm_clr) | pm_set;
      gpe_sts_q <= w1c16(gpe_sts_q, gpio_sci_set, gpe_clr);
      alt_sts_q <= w1c16(alt_sts_q, gpio_smi_set, alt_clr);
      usb_sts_q <= (usb_sts_q & ~usb_clr) | {usb_rise, usb_rise};
      s5_q      <= pbor_rise;
    end
  end

  // ---------------- interrupt combining ----------------
  logic pbor_sts, gbl_sts, ssmi_sts;
  logic [NWAKE-1:0] wake_sts;
  assign pbor_sts = pm_sts_q[B_PBOR];
  assign gbl_sts  = pm_sts_q[B_GBL];
  assign wake_sts = pm_sts_q[B_WAKE +: NWAKE];
  assign ssmi_sts = pm_sts_q[B_SSMI];

  logic sci_terms, smi_terms;
  assign sci_terms = (|(gpe_sts_q & gpe_en_q)) || (|(wake_sts & wake_en_q)) || pbor_sts;
  assign smi_terms = (|(alt_sts_q & alt_en_q)) || (usb_sts_q[1] && (&usb_en_q)) || ssmi_sts;

  assign sci_o    = (sci_en && sci_terms) || gbl_sts;
  assign smi_o    = smi_gen && smi_terms;
  assign s5_req_o = s5_q;

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL:    reg_rdata_o[1:0]         = ctrl_q;
      A_PM_STS:  reg_rdata_o[PM_W-1:0]    = pm_sts_q;
      A_PM_EN:   reg_rdata_o[NWAKE-1:0]   = wake_en_q;
      A_GPE_STS: reg_rdata_o[16 +: NPIN]  = gpe_sts_q;
      A_GPE_EN:  reg_rdata_o[16 +: NPIN]  = gpe_en_q;
      A_ALT_SMI: reg_rdata_o              = {alt_sts_q, alt_en_q};
      A_USB:     reg_rdata_o[3:0]         = {usb_en_q, usb_sts_q};
      A_ROUTE:   reg_rdata_o              = route_q;
      default:   reg_rdata_o              = '0;
    endcase
  end
endmodule

// File: rtl/evr_router_chk.sv
module evr_router_chk (
  input logic clk,
  input logic rst_n,
  input logic sci_o,
  input logic smi_o,
  input logic sci_en,
  input logic smi_gen,
  input logic gbl_sts,
  input logic pbor_sts,
  input logic pbor_clr,
  input logic s5_req_o,
  input logic ssmi_cmpl_o,
  input logic ssmi_ack_i,
  input logic ssmi_pend
);
  p_gbl_forces_sci_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gbl_sts |-> sci_o);

  p_sci_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sci_en && !gbl_sts) |-> !sci_o);

  p_smi_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smi_gen |-> !smi_o);

  p_pbor_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pbor_sts && !pbor_clr) |=> pbor_sts);

  p_s5_sets_pbor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s5_req_o |-> pbor_sts);

  p_s5_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s5_req_o |=> !s5_req_o);

  p_cmpl_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ssmi_cmpl_o |-> ($past(ssmi_ack_i) && $past(ssmi_pend)));

  p_cmpl_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ssmi_cmpl_o |=> !ssmi_cmpl_o);
endmodule

bind evr_router evr_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sci_o(sci_o), .smi_o(smi_o),
  .sci_en(sci_en), .smi_gen(smi_gen), .gbl_sts(gbl_sts), .pbor_sts(pbor_sts),
  .pbor_clr(pbor_clr), .s5_req_o(s5_req_o), .ssmi_cmpl_o(ssmi_cmpl_o),
  .ssmi_ack_i(ssmi_ack_i), .ssmi_pend(ssmi_pend));

// File: tb/evr_router_bench.sv
module evr_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  gpio_core = '0, gpio_sus = '0;
  logic [3:0]  wake_n = 4'hF;
  logic        usb_we = 0, pbor = 0, gbl_req = 0, ssmi_req = 0, ssmi_ack = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        smi, sci, ssmi_cmpl, s5_req;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evr_router u_evr_router (
    .clk(clk), .rst_n(rst_n), .gpio_core_i(gpio_core), .gpio_sus_i(gpio_sus),
    .pcie_wake_n_i(wake_n), .usb_we_i(usb_we), .pwrbtn_ovr_i(pbor),
    .gbl_req_i(gbl_req), .ssmi_req_i(ssmi_req), .ssmi_ack_i(ssmi_ack),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .smi_o(smi), .sci_o(sci),
    .ssmi_cmpl_o(ssmi_cmpl), .s5_req_o(s5_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_0000);
    wr(3'd5, 32'hFFFF_0000);
    wr(3'd6, 32'h0000_0003);
  endtask

  // R11: everything zero after reset
  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      check("R11 reg", v, 32'h0);
    end
    check("R11 outputs", {28'h0, smi, sci, ssmi_cmpl, s5_req}, 32'h0);
  endtask

  // R1 R2 R3: every route code against every enable pair on two pins
  task automatic t_routes();
    logic [31:0] v;
    int pins [2] = '{5, 10};
    wr(3'd0, 32'h3);
    foreach (pins[p]) begin
      for (int rt = 0; rt < 4; rt++) begin
        for (int en = 0; en < 4; en++) begin
          int j = pins[p];
          logic e_sci, e_smi;
          wr(3'd7, 32'(rt) << (2*j));
          wr(3'd4, 32'(en & 1) << (16 + j));
          wr(3'd5, 32'hFFFF_0000 | (32'((en >> 1) & 1) << j));
          wr(3'd3, 32'hFFFF_0000);
          @(negedge clk);
          if (j < 8) gpio_sus[j] = 1'b1; else gpio_core[j-8] = 1'b1;
          idle(4);
          gpio_sus = '0; gpio_core = '0;
          idle(3);
          e_sci = (rt == 2) && (en[0] == 1'b1);
          e_smi = (rt == 1) && (en[1] == 1'b1);
          rd(3'd3, v);
          check("R1 R3 gpio sci status", v, {e_sci ? (32'h1 << (16 + j)) : 32'h0});
          rd(3'd5, v);
          check("R2 R3 gpio smi status", v[31:16], {e_smi ? (16'h1 << j) : 16'h0});
          check("R1 sci_o", {31'h0, sci}, {31'h0, e_sci});
          check("R2 smi_o", {31'h0, smi}, {31'h0, e_smi});
        end
      end
    end
    wr(3'd7, 32'h0);
    clear_all();
  endtask

  // R12 R9 R8: edge only, W1C, SCI gating
  task automatic t_gpio_hold();
    logic [31:0] v;
    wr(3'd0, 32'h1);
    wr(3'd7, 32'h2 << (2*3));            // suspend pin 3 -> SCI
    wr(3'd4, 32'h1 << 19);
    gpio_sus[3] = 1'b1;
    idle(5);
    rd(3'd3, v);
    check("R12 held pin sets once", v, 32'h1 << 19);
    wr(3'd0, 32'h0);
    check("R8 sci gated off", {31'h0, sci}, 32'h0);
    wr(3'd0, 32'h1);
    check("R8 sci gated on", {31'h0, sci}, 32'h1);
    wr(3'd3, 32'h1 << 19);
    idle(3);
    rd(3'd3, v);
    check("R9 R12 cleared, held pin no re-set", v, 32'h0);
    gpio_sus = '0;
    idle(3);
    wr(3'd7, 32'h0);
    wr(3'd4, 32'h0);
  endtask

  // R4 R9: wake level, enable gating, event beats clear
  task automatic t_wake();
    logic [31:0] v;
    wr(3'd0, 32'h1);
    wr(3'd2, 32'h0);
    @(negedge clk); wake_n[2] = 1'b0;
    idle(4);
    rd(3'd1, v);
    check("R4 wake status w/o enable", v, 32'h10);
    check("R4 no sci w/o enable", {31'h0, sci}, 32'h0);
    wr(3'd2, 32'h4);
    check("R4 sci with enable", {31'h0, sci}, 32'h1);
    wr(3'd1, 32'h10);
    rd(3'd1, v);
    check("R9 held wake wins over clear", v, 32'h10);
    wake_n = 4'hF;
    idle(4);
    wr(3'd1, 32'h10);
    rd(3'd1, v);
    check("R9 wake cleared", v, 32'h0);
    check("R4 sci drops", {31'h0, sci}, 32'h0);
    wr(3'd2, 32'h0);
  endtask

  // R5: USB edge and double enable
  task automatic t_usb();
    logic [31:0] v;
    wr(3'd0, 32'h2);
    @(negedge clk); usb_we = 1'b1;
    idle(2);
    rd(3'd6, v);
    check("R5 usb status both", v, 32'h3);
    check("R5 no smi w/o enables", {31'h0, smi}, 32'h0);
    wr(3'd6, 32'h4);
    check("R5 one enable", {31'h0, smi}, 32'h0);
    wr(3'd6, 32'hC);
    check("R5 both enables", {31'h0, smi}, 32'h1);
    wr(3'd0, 32'h0);
    check("R8 smi global gate", {31'h0, smi}, 32'h0);
    wr(3'd6, 32'h3);
    usb_we = 1'b0;
    rd(3'd6, v);
    check("R5 usb cleared", v, 32'h0);
  endtask

  // R6: button override, S5 pulse, persistence
  task automatic t_pbor();
    logic [31:0] v;
    wr(3'd0, 32'h0);
    @(negedge clk); pbor = 1'b1;
    @(negedge clk);
    check("R6 s5 pulse", {31'h0, s5_req}, 32'h1);
    @(negedge clk);
    check("R6 s5 single", {31'h0, s5_req}, 32'h0);
    pbor = 1'b0;
    idle(3);
    rd(3'd1, v);
    check("R6 status persists", v, 32'h1);
    check("R6 no sci while disabled", {31'h0, sci}, 32'h0);
    wr(3'd0, 32'h1);
    check("R6 residual raises sci", {31'h0, sci}, 32'h1);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h1);
    wr(3'd0, 32'h1);
    check("R6 cleared first, no sci", {31'h0, sci}, 32'h0);
    wr(3'd0, 32'h0);
  endtask

  // R7 R9: global status override and set-beats-clear
  task automatic t_gbl();
    logic [31:0] v;
    @(negedge clk); gbl_req = 1'b1;
    @(negedge clk); gbl_req = 1'b0;
    check("R7 sci with sci_en=0", {31'h0, sci}, 32'h1);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'd1; reg_wdata = 32'h2; gbl_req = 1'b1;
    @(negedge clk);
    reg_wr = 0; gbl_req = 1'b0;
    rd(3'd1, v);
    check("R9 request beats clear", v, 32'h2);
    wr(3'd1, 32'h2);
    rd(3'd1, v);
    check("R9 gbl cleared", v, 32'h0);
    check("R7 sci drops", {31'h0, sci}, 32'h0);
  endtask

  // R10: sync SMI completion held for acknowledge
  task automatic t_ssmi();
    logic [31:0] v;
    @(negedge clk); ssmi_ack = 1'b1;
    @(negedge clk); ssmi_ack = 1'b0;
    check("R10 ack without request", {31'h0, ssmi_cmpl}, 32'h0);
    wr(3'd0, 32'h2);
    @(negedge clk); ssmi_req = 1'b1;
    @(negedge clk); ssmi_req = 1'b0;
    check("R10 smi from sync request", {31'h0, smi}, 32'h1);
    rd(3'd1, v);
    check("R10 status bit 6", v, 32'h40);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R10 held before ack", {31'h0, ssmi_cmpl}, 32'h0);
    end
    ssmi_ack = 1'b1;
    @(negedge clk); ssmi_ack = 1'b0;
    check("R10 completion after ack", {31'h0, ssmi_cmpl}, 32'h1);
    @(negedge clk);
    check("R10 completion single", {31'h0, ssmi_cmpl}, 32'h0);
    wr(3'd1, 32'h40);
    check("R10 smi drops", {31'h0, smi}, 32'h0);
    wr(3'd0, 32'h0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_routes();
    t_gpio_hold();
    t_wake();
    t_usb();
    t_pbor();
    t_gbl();
    t_ssmi();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule